// File: doc/BRIEF.md
# Hall Sensor Speed Estimator

This block turns the three Hall sensor bits of a brushless motor into a sector position, a rotation direction and a signed, low-pass filtered speed estimate. It is clocked continuously but does its work once per control tick, marked by a one-cycle `tick` strobe. On each tick the Hall bits are sampled. A change of Hall state counts as a commutation event. The number of ticks between events is counted, with a saturating limit, and the last complete count is held as the commutation period.

After each tick a sequential divider turns the held period into a raw speed. The raw speed is forced to zero when the period has timed out or when the direction has just reversed. The raw speed then passes through a percentage-weighted first-order filter. Two flags with hysteresis report whether the motor runs fast and whether the commutation period jitters from one event to the next. The Hall-code-to-sector table is a parameter.

Top module: `hall_speed_est`

## Requirements
- R1: The Hall code is A*4+B*2+C, where A is `hall_in[2]`, B is `hall_in[1]` and C is `hall_in[0]`. The code is mapped to a sector 0..5 through an 8-entry parameter table. The default table maps codes 5,4,6,2,3,1 to sectors 0,1,2,3,4,5 and maps codes 0 and 7 to sector 0. `sector` shows the sector of the last event.
- R2: A commutation event is taken on a tick when the XOR of the three sampled Hall bits and the three bits held from the previous tick is 1.
- R3: On an event the new sector minus the previous sector is formed as a signed value. `dir` becomes +1 (2'b01) if that difference is 1 or -5, and -1 (2'b11) otherwise.
- R4: On a tick without an event, `tick_count` is first clipped to MAX_CNT and then incremented, so it never exceeds MAX_CNT+1. On an event, `period` takes the old count and `tick_count` restarts at 1.
- R5: After reset, `tick_count` and `period` equal MAX_CNT. `dir`, `sector`, `period_delta`, `speed`, `speed_valid` and both flags are zero.
- R6: The raw speed is zero in three cases: `tick_count` exceeds MAX_CNT, `dir` differs from its value before the last event, or `dir` is 0. Otherwise it is `dir` times SPD_COEF/`period`, truncated.
- R7: After every tick, `speed` becomes ((100-FILT_K)*speed + FILT_K*raw)/100, truncated toward zero. A one-cycle `speed_valid` pulse marks the update, and `speed` changes at no other time.
- R8: `fast_flag` sets when |speed| ≥ SPD_HI and clears when |speed| ≤ SPD_LO. Otherwise it holds.
- R9: On each event, `period_delta` takes the new period minus the old period. `jitter_flag` sets when |period_delta| ≥ JIT_HI and clears when it is ≤ JIT_LO.
- R10: Without a tick, a change on `hall_in` has no effect: `sector`, `dir` and `tick_count` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Control tick strobe, one cycle wide |
| hall_in | input | 3 | Hall bits, [2]=A, [1]=B, [0]=C |
| sector | output | 3 | Sector of the last event |
| dir | output | 2 | Signed direction: +1, -1, 0 after reset |
| tick_count | output | CNT_W (10) | Ticks since the last event, saturating |
| period | output | CNT_W (10) | Last complete commutation period in ticks |
| period_delta | output | CNT_W+1 (11) | Signed change of the period at the last event |
| speed | output | SPD_W (20) | Signed filtered speed |
| speed_valid | output | 1 | One-cycle pulse when `speed` is updated |
| fast_flag | output | 1 | Speed hysteresis flag |
| jitter_flag | output | 1 | Period jitter hysteresis flag |

## Verification
The bench targets the following corner cases:
- The first event after a reversal. A design that skipped the reversal check would emit a full-size speed of the wrong history instead of a zero raw value.
- The sector wrap from 5 to 0 and from 0 to 5. A plain "difference is +1" test would call forward rotation reverse at the wrap.
- A long stall past MAX_CNT. A counter without clipping would keep growing instead of parking at MAX_CNT+1, and the speed would not decay toward zero.
- Invalid codes 0 and 7 mixed into random traffic.
- Hall changes between ticks, which must leave the state alone.
- Negative filter values. Truncation toward zero catches a design that rounds them downward.

// File: rtl/hse_pkg.sv
// Package: shared direction encoding for the Hall speed estimator.
// Assumes two-bit signed direction values throughout the block.
package hse_pkg;
    typedef logic signed [1:0] dir_t;
    localparam dir_t DIR_NONE = 2'sb00;
    localparam dir_t DIR_FWD  = 2'sb01;
    localparam dir_t DIR_REV  = 2'sb11;
endpackage

// File: rtl/hse_hyst.sv
// Hysteresis flag: sets when a magnitude reaches HI, clears at or below LO.
// Assumes LO < HI; the flag is only re-evaluated when upd is high.
module hse_hyst #(
    parameter int W  = 16,
    parameter int HI = 100,
    parameter int LO = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] mag,
    output logic         flag
);
    localparam logic [W-1:0] HI_V = W'(HI);
    localparam logic [W-1:0] LO_V = W'(LO);

    // Flag register with set/clear band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (upd) begin
            if (mag >= HI_V)      flag <= 1'b1;
            else if (mag <= LO_V) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/hse_hall_decode.sv
// Hall decoder: samples the Hall bits per tick, detects a state change by
// parity of old and new bits, maps the code to a sector and derives the
// direction from the modular sector step. Assumes tick is a one-cycle strobe.
module hse_hall_decode
    import hse_pkg::*;
#(
    parameter logic [23:0] HALL_MAP = {3'd0, 3'd2, 3'd0, 3'd1, 3'd4, 3'd3, 3'd5, 3'd0}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] hall_in,
    output logic       hall_evt,
    output logic [2:0] sector_q,
    output dir_t       dir_q,
    output dir_t       dir_prev_q
);
    logic [2:0]        map_tbl [8];
    logic [2:0]        hall_q;
    logic [2:0]        sec_new;
    logic signed [3:0] step;
    logic              fwd;

    // Unpack the code-to-sector table.
    for (genvar g = 0; g < 8; g++) begin : g_map
        assign map_tbl[g] = HALL_MAP[3*g +: 3];
    end

    // Event detection and sector step evaluation.
    always_comb begin
        hall_evt = tick & (^{hall_in, hall_q});
        sec_new  = map_tbl[hall_in];
        step     = $signed({1'b0, sec_new}) - $signed({1'b0, sector_q});
        fwd      = (step == 4'sd1) || (step == -4'sd5);
    end

    // Hall sample, sector and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hall_q     <= 3'b000;
            sector_q   <= 3'd0;
            dir_q      <= DIR_NONE;
            dir_prev_q <= DIR_NONE;
        end else if (tick) begin
            hall_q <= hall_in;
            if (hall_evt) begin
                sector_q   <= sec_new;
                dir_prev_q <= dir_q;
                dir_q      <= fwd ? DIR_FWD : DIR_REV;
            end
        end
    end
endmodule

// File: rtl/hse_period_counter.sv
// Period counter: counts ticks between Hall events with clipping at MAX_CNT,
// latches the completed period and its change, and flags period jitter.
// Assumes CNT_W can hold MAX_CNT+1.
module hse_period_counter #(
    parameter int MAX_CNT = 1000,
    parameter int CNT_W   = 10,
    parameter int JIT_HI  = 8,
    parameter int JIT_LO  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    hall_evt,
    output logic [CNT_W-1:0]        cnt_q,
    output logic [CNT_W-1:0]        period_q,
    output logic signed [CNT_W:0]   delta_q,
    output logic                    timeout,
    output logic                    jitter_flag
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CNT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic signed [CNT_W:0] delta_nx;
    logic [CNT_W:0]        delta_abs;
    logic [CNT_W-1:0]      clipped;

    // Next period change, its magnitude and the clipped count.
    always_comb begin
        delta_nx  = $signed({1'b0, cnt_q}) - $signed({1'b0, period_q});
        delta_abs = delta_nx[CNT_W] ? $unsigned(-delta_nx) : $unsigned(delta_nx);
        clipped   = (cnt_q < MAX_C) ? cnt_q : MAX_C;
        timeout   = cnt_q > MAX_C;
    end

    // Counter, period and delta registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= MAX_C;
            period_q <= MAX_C;
            delta_q  <= '0;
        end else if (tick) begin
            if (hall_evt) begin
                period_q <= cnt_q;
                delta_q  <= delta_nx;
                cnt_q    <= ONE_C;
            end else begin
                cnt_q <= clipped + ONE_C;
            end
        end
    end

    hse_hyst #(.W(CNT_W + 1), .HI(JIT_HI), .LO(JIT_LO)) u_jit_hyst (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (hall_evt),
        .mag  (delta_abs),
        .flag (jitter_flag)
    );
endmodule

// File: rtl/hse_seq_divider.sv
// Restoring unsigned divider, one quotient bit per cycle, N_W cycles.
// Assumes the divisor is nonzero; a new start restarts the operation.
module hse_seq_divider #(
    parameter int N_W = 18,
    parameter int D_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int S_W = $clog2(N_W + 1);

    logic [D_W:0]   rem;
    logic [D_W-1:0] dvs;
    logic [S_W-1:0] steps;
    logic           busy;
    logic [D_W:0]   trial;
    logic [D_W:0]   diff;
    logic           take;
    logic           unused_rem_top;

    // One restoring step.
    always_comb begin
        trial = {rem[D_W-1:0], quotient[N_W-1]};
        diff  = trial - {1'b0, dvs};
        take  = trial >= {1'b0, dvs};
    end
    assign unused_rem_top = rem[D_W];

    // Iteration control and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            dvs      <= '0;
            quotient <= '0;
            steps    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem      <= '0;
                dvs      <= divisor;
                quotient <= dividend;
                steps    <= S_W'(N_W);
                busy     <= 1'b1;
            end else if (busy) begin
                rem      <= take ? diff : trial;
                quotient <= {quotient[N_W-2:0], take};
                steps    <= steps - S_W'(1);
                if (steps == S_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hse_speed_filter.sv
// Speed path: captures the zeroing conditions and the sign at start, divides
// the speed coefficient by the period, then applies the percentage IIR filter
// and the speed hysteresis flag. Assumes period is never zero.
module hse_speed_filter
    import hse_pkg::*;
#(
    parameter int SPD_W    = 20,
    parameter int CNT_W    = 10,
    parameter int SPD_COEF = 200000,
    parameter int FILT_K   = 30,
    parameter int SPD_HI   = 2000,
    parameter int SPD_LO   = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        period,
    input  dir_t                    dir,
    input  dir_t                    dir_prev,
    input  logic                    timeout,
    output logic signed [SPD_W-1:0] speed,
    output logic                    speed_valid,
    output logic                    fast_flag
);
    localparam int CO_W  = $clog2(SPD_COEF + 1);
    localparam int ACC_W = SPD_W + 8;
    localparam logic signed [ACC_W-1:0] K_NEW   = ACC_W'(FILT_K);
    localparam logic signed [ACC_W-1:0] K_OLD   = ACC_W'(100 - FILT_K);
    localparam logic signed [ACC_W-1:0] HUNDRED = ACC_W'(100);

    logic                    zero_q;
    logic                    neg_q;
    logic                    div_done;
    logic [CO_W-1:0]         quo;
    logic signed [ACC_W-1:0] raw_ext;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] nxt_wide;
    logic signed [SPD_W-1:0] spd_next;
    logic [SPD_W-1:0]        spd_abs;
    logic [ACC_W-SPD_W-1:0]  unused_nxt_top;

    // Capture zeroing conditions and sign when a computation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q <= 1'b1;
            neg_q  <= 1'b0;
        end else if (start) begin
            zero_q <= timeout || (dir == DIR_NONE) || (dir != dir_prev);
            neg_q  <= dir == DIR_REV;
        end
    end

    hse_seq_divider #(.N_W(CO_W), .D_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .dividend(CO_W'(SPD_COEF)),
        .divisor (period),
        .done    (div_done),
        .quotient(quo)
    );

    // Raw speed, weighted sum and truncating division by 100.
    always_comb begin
        raw_ext  = $signed({{(ACC_W - CO_W){1'b0}}, quo});
        if (neg_q)  raw_ext = -raw_ext;
        if (zero_q) raw_ext = '0;
        acc      = K_OLD * ACC_W'(speed) + K_NEW * raw_ext;
        nxt_wide = acc / HUNDRED;
        spd_next = nxt_wide[SPD_W-1:0];
        spd_abs  = spd_next[SPD_W-1] ? $unsigned(-spd_next) : $unsigned(spd_next);
    end
    assign unused_nxt_top = nxt_wide[ACC_W-1:SPD_W];

    // Filtered speed state and its update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed       <= '0;
            speed_valid <= 1'b0;
        end else begin
            speed_valid <= div_done;
            if (div_done) speed <= spd_next;
        end
    end

    hse_hyst #(.W(SPD_W), .HI(SPD_HI), .LO(SPD_LO)) u_spd_hyst (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (div_done),
        .mag  (spd_abs),
        .flag (fast_flag)
    );
endmodule

// File: rtl/hall_speed_est.sv
// Top level: Hall decoding, tick period counting and filtered speed.
// Assumes ticks are spaced by more than the divider latency plus three cycles.
module hall_speed_est
    import hse_pkg::*;
#(
    parameter logic [23:0] HALL_MAP = {3'd0, 3'd2, 3'd0, 3'd1, 3'd4, 3'd3, 3'd5, 3'd0},
    parameter int MAX_CNT  = 1000,
    parameter int SPD_W    = 20,
    parameter int SPD_COEF = 200000,
    parameter int FILT_K   = 30,
    parameter int SPD_HI   = 2000,
    parameter int SPD_LO   = 1000,
    parameter int JIT_HI   = 8,
    parameter int JIT_LO   = 3,
    localparam int CNT_W   = $clog2(MAX_CNT + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic [2:0]              hall_in,
    output logic [2:0]              sector,
    output logic signed [1:0]       dir,
    output logic [CNT_W-1:0]        tick_count,
    output logic [CNT_W-1:0]        period,
    output logic signed [CNT_W:0]   period_delta,
    output logic signed [SPD_W-1:0] speed,
    output logic                    speed_valid,
    output logic                    fast_flag,
    output logic                    jitter_flag
);
    logic hall_evt;
    logic timeout;
    logic start_q;
    dir_t dir_prev;

    // Launch the speed computation one cycle after the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= tick;
    end

    hse_hall_decode #(.HALL_MAP(HALL_MAP)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hall_in   (hall_in),
        .hall_evt  (hall_evt),
        .sector_q  (sector),
        .dir_q     (dir),
        .dir_prev_q(dir_prev)
    );

    hse_period_counter #(
        .MAX_CNT(MAX_CNT), .CNT_W(CNT_W), .JIT_HI(JIT_HI), .JIT_LO(JIT_LO)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hall_evt   (hall_evt),
        .cnt_q      (tick_count),
        .period_q   (period),
        .delta_q    (period_delta),
        .timeout    (timeout),
        .jitter_flag(jitter_flag)
    );

    hse_speed_filter #(
        .SPD_W(SPD_W), .CNT_W(CNT_W), .SPD_COEF(SPD_COEF), .FILT_K(FILT_K),
        .SPD_HI(SPD_HI), .SPD_LO(SPD_LO)
    ) u_spd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_q),
        .period     (period),
        .dir        (dir),
        .dir_prev   (dir_prev),
        .timeout    (timeout),
        .speed      (speed),
        .speed_valid(speed_valid),
        .fast_flag  (fast_flag)
    );
endmodule

// File: rtl/hse_checker.sv
// Checker: temporal properties of the Hall speed estimator ports.
// Attached to every instance of the top through the bind below.
module hse_checker #(
    parameter int MAX_CNT = 1000,
    parameter int CNT_W   = 10,
    parameter int SPD_W   = 20,
    parameter int SPD_HI  = 2000,
    parameter int SPD_LO  = 1000,
    parameter int JIT_HI  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic [2:0]              sector,
    input logic signed [1:0]       dir,
    input logic [CNT_W-1:0]        tick_count,
    input logic [CNT_W-1:0]        period,
    input logic signed [CNT_W:0]   period_delta,
    input logic signed [SPD_W-1:0] speed,
    input logic                    speed_valid,
    input logic                    fast_flag,
    input logic                    jitter_flag
);
    logic [SPD_W-1:0] spd_mag;
    logic [CNT_W:0]   dlt_mag;

    // Magnitudes of the signed outputs.
    always_comb begin
        spd_mag = speed[SPD_W-1] ? $unsigned(-speed) : $unsigned(speed);
        dlt_mag = period_delta[CNT_W] ? $unsigned(-period_delta) : $unsigned(period_delta);
    end

    a_r1_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
        sector <= 3'd5);
    a_r4_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        period != '0);
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_count != '0) && (tick_count <= CNT_W'(MAX_CNT + 1)));
    a_r4_restart_with_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period) |-> tick_count == CNT_W'(1));
    a_r3_dir_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir) |-> (dir == 2'sb01 || dir == 2'sb11));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(tick_count) && $stable(sector) && $stable(dir)));
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        speed_valid |=> !speed_valid);
    a_r7_speed_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed) |-> speed_valid);
    a_r8_fast_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_flag) |-> spd_mag >= SPD_W'(SPD_HI));
    a_r8_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_flag) |-> spd_mag <= SPD_W'(SPD_LO));
    a_r9_jitter_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jitter_flag) |-> dlt_mag >= (CNT_W + 1)'(JIT_HI));
endmodule

bind hall_speed_est hse_checker #(
    .MAX_CNT(MAX_CNT), .CNT_W(CNT_W), .SPD_W(SPD_W),
    .SPD_HI(SPD_HI), .SPD_LO(SPD_LO), .JIT_HI(JIT_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sector      (sector),
    .dir         (dir),
    .tick_count  (tick_count),
    .period      (period),
    .period_delta(period_delta),
    .speed       (speed),
    .speed_valid (speed_valid),
    .fast_flag   (fast_flag),
    .jitter_flag (jitter_flag)
);

// File: tb/hall_speed_est_bench.sv
// Bench for the Hall speed estimator: directed and seeded random rotation
// patterns checked against a behavioural model kept in bench functions.
module hall_speed_est_bench;
    localparam int MAX_CNT  = 1000;
    localparam int SPD_W    = 20;
    localparam int SPD_COEF = 200000;
    localparam int FILT_K   = 30;
    localparam int SPD_HI   = 2000;
    localparam int SPD_LO   = 1000;
    localparam int JIT_HI   = 8;
    localparam int JIT_LO   = 3;
    localparam int CNT_W    = $clog2(MAX_CNT + 2);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tick = 1'b0;
    logic [2:0]              hall_in = 3'd5;
    logic [2:0]              sector;
    logic signed [1:0]       dir;
    logic [CNT_W-1:0]        tick_count;
    logic [CNT_W-1:0]        period;
    logic signed [CNT_W:0]   period_delta;
    logic signed [SPD_W-1:0] speed;
    logic                    speed_valid;
    logic                    fast_flag;
    logic                    jitter_flag;

    int errors = 0;
    int checks = 0;

    // Model state.
    int m_hq = 0, m_sec = 0, m_dir = 0, m_dirp = 0;
    int m_cnt = MAX_CNT, m_per = MAX_CNT, m_delta = 0, m_spd = 0;
    int m_fast = 0, m_jit = 0;
    int pos = 0;

    always #5 clk = ~clk;

    hall_speed_est #(
        .MAX_CNT(MAX_CNT), .SPD_W(SPD_W), .SPD_COEF(SPD_COEF), .FILT_K(FILT_K),
        .SPD_HI(SPD_HI), .SPD_LO(SPD_LO), .JIT_HI(JIT_HI), .JIT_LO(JIT_LO)
    ) u_hall_speed_est (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hall_in(hall_in),
        .sector(sector), .dir(dir), .tick_count(tick_count), .period(period),
        .period_delta(period_delta), .speed(speed), .speed_valid(speed_valid),
        .fast_flag(fast_flag), .jitter_flag(jitter_flag)
    );

    // Sector of a Hall code, per R1.
    function automatic int sec_of(input int code);
        case (code)
            5: return 0;  4: return 1;  6: return 2;
            2: return 3;  3: return 4;  1: return 5;
            default: return 0;
        endcase
    endfunction

    // Hall code of a sector for forward rotation, per R1.
    function automatic int code_of(input int s);
        case (s)
            0: return 5;  1: return 4;  2: return 6;
            3: return 2;  4: return 3;  default: return 1;
        endcase
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of one tick (R2..R9).
    task automatic model_tick(input int h);
        int par, s, d, raw;
        par = (h ^ m_hq);
        par = (par & 1) ^ ((par >> 1) & 1) ^ ((par >> 2) & 1);
        if (par != 0) begin
            s = sec_of(h);
            d = s - m_sec;
            m_dirp = m_dir;
            m_dir = (d == 1 || d == -5) ? 1 : -1;
            m_sec = s;
            m_delta = m_cnt - m_per;
            m_per = m_cnt;
            m_cnt = 1;
            if (iabs(m_delta) >= JIT_HI) m_jit = 1;
            else if (iabs(m_delta) <= JIT_LO) m_jit = 0;
        end else begin
            m_cnt = ((m_cnt < MAX_CNT) ? m_cnt : MAX_CNT) + 1;
        end
        m_hq = h;
        if (m_cnt > MAX_CNT || m_dir != m_dirp || m_dir == 0) raw = 0;
        else raw = m_dir * (SPD_COEF / m_per);
        m_spd = ((100 - FILT_K) * m_spd + FILT_K * raw) / 100;
        if (iabs(m_spd) >= SPD_HI) m_fast = 1;
        else if (iabs(m_spd) <= SPD_LO) m_fast = 0;
    endtask

    // Apply one tick, wait for the speed update, compare every output.
    task automatic do_tick(input int h);
        bit seen;
        @(negedge clk);
        hall_in = 3'(h);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick(h);
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (speed_valid) seen = 1'b1;
        end
        chk("R7", "speed_valid seen", int'(seen), 1);
        chk("R1", "sector", int'(sector), m_sec);
        chk("R3", "dir", int'(dir), m_dir);
        chk("R2 R4", "tick_count", int'(tick_count), m_cnt);
        chk("R4", "period", int'(period), m_per);
        chk("R9", "period_delta", int'(period_delta), m_delta);
        chk("R9", "jitter_flag", int'(jitter_flag), m_jit);
        chk("R6 R7", "speed", int'(speed), m_spd);
        chk("R8", "fast_flag", int'(fast_flag), m_fast);
    endtask

    // Rotate n events in direction d with per ticks between events.
    task automatic spin(input int d, input int n, input int per);
        for (int e = 0; e < n; e++) begin
            for (int t = 1; t < per; t++) do_tick(code_of(pos));
            pos = (pos + d + 6) % 6;
            do_tick(code_of(pos));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int code, per, d;
        void'($urandom(32'd7177));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5", "tick_count", int'(tick_count), MAX_CNT);
        chk("R5", "period", int'(period), MAX_CNT);
        chk("R5", "dir", int'(dir), 0);
        chk("R5", "sector", int'(sector), 0);
        chk("R5", "speed", int'(speed), 0);
        chk("R5", "flags", int'({fast_flag, jitter_flag, speed_valid}), 0);

        // Forward rotation across the 5->0 wrap (R3), speed rising (R8).
        pos = 0;
        spin(1, 14, 20);
        // Reversal: first event must zero the raw speed (R6), wrap 0->5.
        spin(-1, 10, 25);
        // Period jitter directed pattern (R9).
        spin(1, 3, 10);
        spin(1, 2, 22);
        spin(1, 4, 22);

        // Seeded random rotation with occasional invalid codes.
        for (int e = 0; e < 40; e++) begin
            per = 3 + int'($urandom % 60);
            d = ($urandom % 2 == 0) ? 1 : -1;
            if ($urandom % 8 == 0) begin
                code = ($urandom % 2 == 0) ? 0 : 7;
                do_tick(code);
                pos = sec_of(code);
            end
            spin(d, 1, per);
        end

        // R10: Hall change with no tick leaves state alone.
        begin
            int s0, c0, d0;
            s0 = int'(sector); c0 = int'(tick_count); d0 = int'(dir);
            @(negedge clk);
            hall_in = 3'(code_of((pos + 1) % 6));
            repeat (6) @(negedge clk);
            chk("R10", "sector held", int'(sector), s0);
            chk("R10", "tick_count held", int'(tick_count), c0);
            chk("R10", "dir held", int'(dir), d0);
            hall_in = 3'(code_of(pos));
        end

        // Stall past the limit: count saturates, speed decays (R4, R6).
        for (int t = 0; t < MAX_CNT + 60; t++) do_tick(code_of(pos));
        chk("R4", "saturated count", int'(tick_count), MAX_CNT + 1);
        chk("R6", "stalled speed", int'(speed), 0);
        chk("R8", "fast cleared", int'(fast_flag), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule